// File: doc/BRIEF.md
# Packet DMA Host Register Port

This block is the register front end that a host processor uses to reach a packet DMA interface. Each request carries an address, a direction, an access size, write data and a tag. Only the low 12 address bits pick a register. The block checks every access against the register's size and its read and write permissions. It holds the programmable settings and the two descriptor words. When a status register is read, the block builds the value from the live levels of the receive and transmit FIFOs.

Each direction has a pair of status registers. The "done" register always answers at once. The "hold" alias returns the same word, but if the matching engine is busy, the read is parked. It is answered in the cycle after that engine reports idle. The response then carries the status as it is at that moment. Other accesses go on being served while a read is parked. A command write can restore every register to its default value and pulse a clear to both FIFOs.

Top module: `pkt_host_regport`

## Requirements
- R1: Only `req_addr[11:0]` selects a register. The upper address bits have no effect on the decode or on the data returned.
- R2: The size code is 0 for a 4-byte access and 1 for an 8-byte access. An access whose size does not match the register's width gets an error response. The 8-byte registers are at offsets 0x018, 0x020, 0x028, 0x030, 0x038, 0x040 and 0x048. The 4-byte registers are at 0x000, 0x004, 0x008, 0x00C, 0x010 and 0x014.
- R3: An access gets an error response in three cases: the offset is not one of those listed, it reads the command register (0x004), or it writes a read-only register (0x018 station address, 0x028/0x030 receive status, 0x040/0x048 transmit status). An error response has zero data.
- R4: An accepted access that is not parked is answered in the next cycle. The response raises `rsp_valid` and echoes the request tag. A write response carries zero data, and a 4-byte read returns its value zero-extended.
- R5: The readable and writable registers are control 0x000, interrupt mask 0x008, transmit copy limit 0x00C, transmit mark 0x010, receive copy limit 0x014, receive descriptor 0x020 and transmit descriptor 0x038. Each returns the last value written. After reset each holds its parameter default, and the station address at 0x018 returns its parameter value.
- R6: The receive status (0x028) returns `rx_pkt_count` zero-extended in bits 15:0. All other bits are zero.
- R7: The transmit status (0x040) returns `tx_pkt_count` in bits 15:0. Bit 16 is set when `tx_free` is less than the transmit copy limit. Bit 17 is set when `tx_occupancy` is less than the transmit mark. All other bits are zero.
- R8: The receive hold alias (0x030) and the transmit hold alias (0x048) return the same word as their status register.
- R9: A read of a hold alias while its engine's idle input is low is parked and produces no response. In the cycle where the engine is idle and a read is parked, `req_ready` is low. At that clock edge the parked read is answered with its own tag and the live status. Receive goes before transmit when both are releasable.
- R10: A read of a hold alias that already has a parked read, while its engine is still busy, gets an error response. The first parked read remains parked.
- R11: A write to the command register (0x004) with bit 0 set restores all registers to their defaults. It also raises `fifo_clear` for one cycle, together with the response. With bit 0 clear, the write has no effect.
- R12: An access that gets an error response changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted at this edge when high |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Access address; low 12 bits decode |
| req_size | input | 1 | 0 for 4 bytes, 1 for 8 bytes |
| req_wdata | input | 64 | Write data |
| req_tag | input | TAG_W | Request identifier echoed in the response |
| rx_pkt_count | input | CNT_W | Packets held in the receive FIFO |
| tx_pkt_count | input | CNT_W | Packets held in the transmit FIFO |
| tx_free | input | LVL_W | Free bytes in the transmit FIFO |
| tx_occupancy | input | LVL_W | Used bytes in the transmit FIFO |
| rx_idle | input | 1 | Receive engine idle |
| tx_idle | input | 1 | Transmit engine idle |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Response is an access error |
| rsp_tag | output | TAG_W | Tag of the answered request |
| rsp_rdata | output | 64 | Read data |
| fifo_clear | output | 1 | One-cycle clear pulse to both FIFOs |

## Verification
Every 12-bit offset is read and written at both sizes, with the upper address bits scrambled. This separates errors caused by the offset, by the size and by the permission, and it shows whether the upper bits are ignored. After the error writes, the registers are read back to show that none of them changed. The receive packet count is swept over its full range. The transmit free space and occupancy are swept in opposite directions across both programmed thresholds, so the full and low flags are seen on both sides of the less-than boundary. The hold reads are driven while the engines are busy, then one engine and then both are made idle. During the wait the status inputs are changed, which checks the release order, the tags, and that the returned value is sampled at release time.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

    localparam int OFF_W = 12;

    typedef enum logic [3:0] {
        RID_CTRL, RID_CMD, RID_MASK, RID_TXCOPY, RID_TXMARK, RID_RXCOPY,
        RID_STATION, RID_RXDESC, RID_RXSTAT, RID_RXHOLD,
        RID_TXDESC, RID_TXSTAT, RID_TXHOLD, RID_NONE
    } reg_id_e;

    localparam logic [OFF_W-1:0] OFF_CTRL    = 12'h000;
    localparam logic [OFF_W-1:0] OFF_CMD     = 12'h004;
    localparam logic [OFF_W-1:0] OFF_MASK    = 12'h008;
    localparam logic [OFF_W-1:0] OFF_TXCOPY  = 12'h00C;
    localparam logic [OFF_W-1:0] OFF_TXMARK  = 12'h010;
    localparam logic [OFF_W-1:0] OFF_RXCOPY  = 12'h014;
    localparam logic [OFF_W-1:0] OFF_STATION = 12'h018;
    localparam logic [OFF_W-1:0] OFF_RXDESC  = 12'h020;
    localparam logic [OFF_W-1:0] OFF_RXSTAT  = 12'h028;
    localparam logic [OFF_W-1:0] OFF_RXHOLD  = 12'h030;
    localparam logic [OFF_W-1:0] OFF_TXDESC  = 12'h038;
    localparam logic [OFF_W-1:0] OFF_TXSTAT  = 12'h040;
    localparam logic [OFF_W-1:0] OFF_TXHOLD  = 12'h048;

    // Bit positions inside the transmit status word
    localparam int TXST_FULL_BIT = 16;
    localparam int TXST_LOW_BIT  = 17;
    localparam int CMD_RESET_BIT = 0;

    typedef struct packed {
        reg_id_e id;
        logic    wide;
        logic    can_rd;
        logic    can_wr;
    } reg_attr_t;

endpackage

// File: rtl/hrp_decode.sv
module hrp_decode
    import hrp_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    output reg_attr_t        attr
);
    always_comb begin
        attr = '{id: RID_NONE, wide: 1'b0, can_rd: 1'b0, can_wr: 1'b0};
        unique case (off)
            OFF_CTRL:    attr = '{id: RID_CTRL,    wide: 1'b0, can_rd: 1'b1, can_wr: 1'b1};
            OFF_CMD:     attr = '{id: RID_CMD,     wide: 1'b0, can_rd: 1'b0, can_wr: 1'b1};
            OFF_MASK:    attr = '{id: RID_MASK,    wide: 1'b0, can_rd: 1'b1, can_wr: 1'b1};
            OFF_TXCOPY:  attr = '{id: RID_TXCOPY,  wide: 1'b0, can_rd: 1'b1, can_wr: 1'b1};
            OFF_TXMARK:  attr = '{id: RID_TXMARK,  wide: 1'b0, can_rd: 1'b1, can_wr: 1'b1};
            OFF_RXCOPY:  attr = '{id: RID_RXCOPY,  wide: 1'b0, can_rd: 1'b1, can_wr: 1'b1};
            OFF_STATION: attr = '{id: RID_STATION, wide: 1'b1, can_rd: 1'b1, can_wr: 1'b0};
            OFF_RXDESC:  attr = '{id: RID_RXDESC,  wide: 1'b1, can_rd: 1'b1, can_wr: 1'b1};
            OFF_RXSTAT:  attr = '{id: RID_RXSTAT,  wide: 1'b1, can_rd: 1'b1, can_wr: 1'b0};
            OFF_RXHOLD:  attr = '{id: RID_RXHOLD,  wide: 1'b1, can_rd: 1'b1, can_wr: 1'b0};
            OFF_TXDESC:  attr = '{id: RID_TXDESC,  wide: 1'b1, can_rd: 1'b1, can_wr: 1'b1};
            OFF_TXSTAT:  attr = '{id: RID_TXSTAT,  wide: 1'b1, can_rd: 1'b1, can_wr: 1'b0};
            OFF_TXHOLD:  attr = '{id: RID_TXHOLD,  wide: 1'b1, can_rd: 1'b1, can_wr: 1'b0};
            default:     attr = '{id: RID_NONE,    wide: 1'b0, can_rd: 1'b0, can_wr: 1'b0};
        endcase
    end
endmodule

// File: rtl/hrp_status.sv
module hrp_status
    import hrp_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int LVL_W = 10
) (
    input  logic [CNT_W-1:0] rx_pkt_count,
    input  logic [CNT_W-1:0] tx_pkt_count,
    input  logic [LVL_W-1:0] tx_free,
    input  logic [LVL_W-1:0] tx_occupancy,
    input  logic [31:0]      tx_copy_lim,
    input  logic [31:0]      tx_mark,
    output logic [63:0]      rx_word,
    output logic [63:0]      tx_word
);
    localparam int CNT_FIELD = 16;
    localparam int PAD_W     = 32 - LVL_W;

    logic [31:0] free_ext, occ_ext;
    logic        full_flag, low_flag;

    assign free_ext  = {{PAD_W{1'b0}}, tx_free};
    assign occ_ext   = {{PAD_W{1'b0}}, tx_occupancy};
    assign full_flag = free_ext < tx_copy_lim;
    assign low_flag  = occ_ext < tx_mark;

    always_comb begin
        rx_word = '0;
        rx_word[CNT_FIELD-1:0] = {{(CNT_FIELD-CNT_W){1'b0}}, rx_pkt_count};
        tx_word = '0;
        tx_word[CNT_FIELD-1:0] = {{(CNT_FIELD-CNT_W){1'b0}}, tx_pkt_count};
        tx_word[TXST_FULL_BIT] = full_flag;
        tx_word[TXST_LOW_BIT]  = low_flag;
    end
endmodule

// File: rtl/hrp_park.sv
module hrp_park #(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             engine_idle,
    input  logic             grant,
    output logic             held,
    output logic [TAG_W-1:0] held_tag,
    output logic             fire
);
    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
    } slot_t;

    slot_t slot_d, slot_q;

    assign held     = slot_q.valid;
    assign held_tag = slot_q.tag;
    assign fire     = slot_q.valid && engine_idle && grant;

    always_comb begin
        slot_d = slot_q;
        if (fire) begin
            slot_d.valid = 1'b0;
        end else if (set) begin
            slot_d.valid = 1'b1;
            slot_d.tag   = set_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end
endmodule

// File: rtl/pkt_host_regport.sv
module pkt_host_regport
    import hrp_pkg::*;
#(
    parameter int          ADDR_W        = 16,
    parameter int          TAG_W         = 4,
    parameter int          CNT_W         = 8,
    parameter int          LVL_W         = 10,
    parameter logic [31:0] CTRL_DFLT     = 32'h0000_0000,
    parameter logic [31:0] MASK_DFLT     = 32'h0000_0013,
    parameter logic [31:0] TXCOPY_DFLT   = 32'd64,
    parameter logic [31:0] TXMARK_DFLT   = 32'd128,
    parameter logic [31:0] RXCOPY_DFLT   = 32'd256,
    parameter logic [63:0] STATION_ADDR  = 64'h0000_0A1B_2C3D_4E5F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_size,
    input  logic [63:0]       req_wdata,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [CNT_W-1:0]  rx_pkt_count,
    input  logic [CNT_W-1:0]  tx_pkt_count,
    input  logic [LVL_W-1:0]  tx_free,
    input  logic [LVL_W-1:0]  tx_occupancy,
    input  logic              rx_idle,
    input  logic              tx_idle,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [63:0]       rsp_rdata,
    output logic              fifo_clear
);
    typedef struct packed {
        logic [31:0]      ctrl;
        logic [31:0]      mask;
        logic [31:0]      txcopy;
        logic [31:0]      txmark;
        logic [31:0]      rxcopy;
        logic [63:0]      rxdesc;
        logic [63:0]      txdesc;
        logic             rsp_valid;
        logic             rsp_err;
        logic [TAG_W-1:0] rsp_tag;
        logic [63:0]      rsp_data;
        logic             fclr;
    } state_t;

    state_t st_d, st_q;

    logic             unused_addr_hi;
    reg_attr_t        attr;
    logic [63:0]      rx_word, tx_word;
    logic             rx_held, tx_held, rx_fire, tx_fire;
    logic [TAG_W-1:0] rx_ptag, tx_ptag;
    logic             rx_set, tx_set;
    logic             bad, park_rx_now, park_tx_now, dup_rx, dup_tx;
    logic [63:0]      rd_val;

    assign unused_addr_hi = ^req_addr[ADDR_W-1:OFF_W];

    hrp_decode u_dec (
        .off  (req_addr[OFF_W-1:0]),
        .attr (attr)
    );

    hrp_status #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_stat (
        .rx_pkt_count (rx_pkt_count),
        .tx_pkt_count (tx_pkt_count),
        .tx_free      (tx_free),
        .tx_occupancy (tx_occupancy),
        .tx_copy_lim  (st_q.txcopy),
        .tx_mark      (st_q.txmark),
        .rx_word      (rx_word),
        .tx_word      (tx_word)
    );

    hrp_park #(.TAG_W(TAG_W)) u_park_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .set         (rx_set),
        .set_tag     (req_tag),
        .engine_idle (rx_idle),
        .grant       (1'b1),
        .held        (rx_held),
        .held_tag    (rx_ptag),
        .fire        (rx_fire)
    );

    hrp_park #(.TAG_W(TAG_W)) u_park_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .set         (tx_set),
        .set_tag     (req_tag),
        .engine_idle (tx_idle),
        .grant       (!rx_fire),
        .held        (tx_held),
        .held_tag    (tx_ptag),
        .fire        (tx_fire)
    );

    // A releasable parked read owns the response slot this cycle
    assign req_ready = !((rx_held && rx_idle) || (tx_held && tx_idle));

    always_comb begin
        dup_rx      = !req_write && attr.id == RID_RXHOLD && !rx_idle && rx_held;
        dup_tx      = !req_write && attr.id == RID_TXHOLD && !tx_idle && tx_held;
        bad         = attr.id == RID_NONE
                   || req_size != attr.wide
                   || (req_write ? !attr.can_wr : !attr.can_rd)
                   || dup_rx || dup_tx;
        park_rx_now = !req_write && attr.id == RID_RXHOLD && !rx_idle;
        park_tx_now = !req_write && attr.id == RID_TXHOLD && !tx_idle;
    end

    always_comb begin
        rd_val = '0;
        unique case (attr.id)
            RID_CTRL:    rd_val = {32'h0, st_q.ctrl};
            RID_MASK:    rd_val = {32'h0, st_q.mask};
            RID_TXCOPY:  rd_val = {32'h0, st_q.txcopy};
            RID_TXMARK:  rd_val = {32'h0, st_q.txmark};
            RID_RXCOPY:  rd_val = {32'h0, st_q.rxcopy};
            RID_STATION: rd_val = STATION_ADDR;
            RID_RXDESC:  rd_val = st_q.rxdesc;
            RID_TXDESC:  rd_val = st_q.txdesc;
            RID_RXSTAT,
            RID_RXHOLD:  rd_val = rx_word;
            RID_TXSTAT,
            RID_TXHOLD:  rd_val = tx_word;
            default:     rd_val = '0;
        endcase
    end

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_err   = 1'b0;
        st_d.rsp_data  = '0;
        st_d.fclr      = 1'b0;
        rx_set         = 1'b0;
        tx_set         = 1'b0;
        if (rx_fire) begin
            st_d.rsp_valid = 1'b1;
            st_d.rsp_tag   = rx_ptag;
            st_d.rsp_data  = rx_word;
        end else if (tx_fire) begin
            st_d.rsp_valid = 1'b1;
            st_d.rsp_tag   = tx_ptag;
            st_d.rsp_data  = tx_word;
        end else if (req_valid) begin
            st_d.rsp_tag = req_tag;
            if (bad) begin
                st_d.rsp_valid = 1'b1;
                st_d.rsp_err   = 1'b1;
            end else if (req_write) begin
                st_d.rsp_valid = 1'b1;
                unique case (attr.id)
                    RID_CTRL:   st_d.ctrl   = req_wdata[31:0];
                    RID_MASK:   st_d.mask   = req_wdata[31:0];
                    RID_TXCOPY: st_d.txcopy = req_wdata[31:0];
                    RID_TXMARK: st_d.txmark = req_wdata[31:0];
                    RID_RXCOPY: st_d.rxcopy = req_wdata[31:0];
                    RID_RXDESC: st_d.rxdesc = req_wdata;
                    RID_TXDESC: st_d.txdesc = req_wdata;
                    RID_CMD: begin
                        if (req_wdata[CMD_RESET_BIT]) begin
                            st_d.ctrl   = CTRL_DFLT;
                            st_d.mask   = MASK_DFLT;
                            st_d.txcopy = TXCOPY_DFLT;
                            st_d.txmark = TXMARK_DFLT;
                            st_d.rxcopy = RXCOPY_DFLT;
                            st_d.rxdesc = '0;
                            st_d.txdesc = '0;
                            st_d.fclr   = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end else if (park_rx_now) begin
                rx_set = 1'b1;
            end else if (park_tx_now) begin
                tx_set = 1'b1;
            end else begin
                st_d.rsp_valid = 1'b1;
                st_d.rsp_data  = rd_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.ctrl   <= CTRL_DFLT;
            st_q.mask   <= MASK_DFLT;
            st_q.txcopy <= TXCOPY_DFLT;
            st_q.txmark <= TXMARK_DFLT;
            st_q.rxcopy <= RXCOPY_DFLT;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_err    = st_q.rsp_err;
    assign rsp_tag    = st_q.rsp_tag;
    assign rsp_rdata  = st_q.rsp_data;
    assign fifo_clear = st_q.fclr;

endmodule

// File: rtl/hrp_checker.sv
module hrp_checker
    import hrp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_size,
    input logic              rx_idle,
    input logic              tx_idle,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [63:0]       rsp_rdata,
    input logic              fifo_clear
);
    logic acc, hold_busy;
    assign acc       = req_valid && req_ready;
    assign hold_busy = !req_write
                    && ((req_addr[OFF_W-1:0] == OFF_RXHOLD && !rx_idle)
                     || (req_addr[OFF_W-1:0] == OFF_TXHOLD && !tx_idle));

    assert_stall_needs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (rx_idle || tx_idle));

    assert_stall_answers_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (rsp_valid && !rsp_err));

    assert_prompt_response_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !hold_busy) |=> rsp_valid);

    assert_error_zero_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == 64'h0));

    assert_station_size_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_addr[OFF_W-1:0] == OFF_STATION && !req_size) |=> rsp_err);

    assert_clear_from_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clear |-> $past(req_valid && req_ready && req_write));
endmodule

bind pkt_host_regport hrp_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .rx_idle    (rx_idle),
    .tx_idle    (tx_idle),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .fifo_clear (fifo_clear)
);

// File: tb/sim_pkt_host_regport.sv
module sim_pkt_host_regport;
    localparam int ADDR_W = 16;
    localparam int TAG_W  = 4;
    localparam int CNT_W  = 8;
    localparam int LVL_W  = 10;
    localparam logic [31:0] D_CTRL = 32'h0, D_MASK = 32'h13, D_TXC = 32'd64,
                            D_TXM = 32'd128, D_RXC = 32'd256;
    localparam logic [63:0] D_STA = 64'h0000_0A1B_2C3D_4E5F;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_ready, req_write = 0, req_size = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic [CNT_W-1:0] rx_pkt_count = '0, tx_pkt_count = '0;
    logic [LVL_W-1:0] tx_free = '0, tx_occupancy = '0;
    logic rx_idle = 1, tx_idle = 1;
    logic rsp_valid, rsp_err, fifo_clear;
    logic [TAG_W-1:0] rsp_tag;
    logic [63:0] rsp_rdata;

    int n_chk = 0, n_bad = 0;
    logic [31:0] m_ctrl, m_mask, m_txc, m_txm, m_rxc;
    logic [63:0] m_rxd, m_txd;

    always #2 clk = ~clk;

    pkt_host_regport #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .CNT_W(CNT_W), .LVL_W(LVL_W)) u0 (.*);

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic model_defaults();
        m_ctrl = D_CTRL; m_mask = D_MASK; m_txc = D_TXC; m_txm = D_TXM;
        m_rxc = D_RXC; m_rxd = '0; m_txd = '0;
    endtask

    function automatic logic [63:0] rx_exp();
        return {48'h0, 8'h0, rx_pkt_count};
    endfunction

    function automatic logic [63:0] tx_exp();
        logic [63:0] v = {48'h0, 8'h0, tx_pkt_count};
        v[16] = {22'h0, tx_free} < m_txc;
        v[17] = {22'h0, tx_occupancy} < m_txm;
        return v;
    endfunction

    // Expected outcome of an access, from the register table in the brief
    task automatic model(input logic [11:0] off, input bit w, input bit sz8,
                         output bit err, output logic [63:0] data);
        bit mapped = 1, wide = 0, rd = 1, wr = 1;
        logic [63:0] v = '0;
        case (off)
            12'h000: v = {32'h0, m_ctrl};
            12'h004: rd = 0;
            12'h008: v = {32'h0, m_mask};
            12'h00C: v = {32'h0, m_txc};
            12'h010: v = {32'h0, m_txm};
            12'h014: v = {32'h0, m_rxc};
            12'h018: begin wide = 1; wr = 0; v = D_STA; end
            12'h020: begin wide = 1; v = m_rxd; end
            12'h028, 12'h030: begin wide = 1; wr = 0; v = rx_exp(); end
            12'h038: begin wide = 1; v = m_txd; end
            12'h040, 12'h048: begin wide = 1; wr = 0; v = tx_exp(); end
            default: mapped = 0;
        endcase
        err  = !mapped || (sz8 != wide) || (w ? !wr : !rd);
        data = (err || w) ? 64'h0 : v;
    endtask

    // Drive one access at a falling edge; sample the response at the next one
    task automatic access(input bit w, input logic [ADDR_W-1:0] a, input bit sz8,
                          input logic [63:0] wd, input logic [TAG_W-1:0] tg,
                          output bit e, output logic [63:0] d, output bit v,
                          output logic [TAG_W-1:0] t);
        req_valid = 1; req_write = w; req_addr = a; req_size = sz8;
        req_wdata = wd; req_tag = tg;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        e = rsp_err; d = rsp_rdata; v = rsp_valid; t = rsp_tag;
    endtask

    task automatic rd_chk(input string rq, input logic [11:0] off, input logic [3:0] hi,
                          input bit sz8);
        bit e, xe, v; logic [63:0] d, xd; logic [TAG_W-1:0] t;
        model(off, 0, sz8, xe, xd);
        access(0, {hi, off}, sz8, 64'h0, hi, e, d, v, t);
        chk({rq, " valid"}, {63'h0, v}, 64'h1);
        chk({rq, " err"}, {63'h0, e}, {63'h0, xe});
        chk({rq, " data"}, d, xd);
        chk({rq, " tag"}, {60'h0, t}, {60'h0, hi});
    endtask

    task automatic wr_do(input string rq, input logic [11:0] off, input bit sz8,
                         input logic [63:0] wd);
        bit e, xe, v; logic [63:0] d, xd; logic [TAG_W-1:0] t;
        model(off, 1, sz8, xe, xd);
        access(1, {4'h5, off}, sz8, wd, 4'h3, e, d, v, t);
        chk({rq, " werr"}, {63'h0, e}, {63'h0, xe});
        chk({rq, " wdata"}, d, 64'h0);
        if (!xe) begin
            case (off)
                12'h000: m_ctrl = wd[31:0];
                12'h008: m_mask = wd[31:0];
                12'h00C: m_txc = wd[31:0];
                12'h010: m_txm = wd[31:0];
                12'h014: m_rxc = wd[31:0];
                12'h020: m_rxd = wd;
                12'h038: m_txd = wd;
                12'h004: if (wd[0]) model_defaults();
                default: ;
            endcase
        end
    endtask

    task automatic readback_all(input string rq);
        rd_chk(rq, 12'h000, 4'h1, 0);
        rd_chk(rq, 12'h008, 4'h2, 0);
        rd_chk(rq, 12'h00C, 4'h3, 0);
        rd_chk(rq, 12'h010, 4'h4, 0);
        rd_chk(rq, 12'h014, 4'h5, 0);
        rd_chk(rq, 12'h018, 4'h6, 1);
        rd_chk(rq, 12'h020, 4'h7, 1);
        rd_chk(rq, 12'h038, 4'h8, 1);
    endtask

    bit done = 0;
    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        bit e, v; logic [63:0] d; logic [TAG_W-1:0] t;
        model_defaults();
        tx_free = 10'd500; tx_occupancy = 10'd40; rx_pkt_count = 8'd17; tx_pkt_count = 8'd3;
        repeat (3) @(negedge clk);
        chk("R4 reset rsp_valid", {63'h0, rsp_valid}, 64'h0);
        chk("R11 reset fifo_clear", {63'h0, fifo_clear}, 64'h0);
        rst_n = 1;
        @(negedge clk);
        chk("R9 ready after reset", {63'h0, req_ready}, 64'h1);
        readback_all("R5 defaults");

        // R1 R2 R3: every offset, both sizes, scrambled upper address bits
        for (int i = 0; i < 1024; i++) begin
            for (int s = 0; s < 2; s++)
                rd_chk("R1 R2 R3 read sweep", 12'(i * 4), 4'(i ^ 9), s[0]);
        end
        // R12: only erroring writes in this sweep; the state must stay put
        for (int i = 0; i < 1024; i++) begin
            for (int s = 0; s < 2; s++) begin
                bit xe; logic [63:0] xd;
                model(12'(i * 4), 1, s[0], xe, xd);
                if (xe) wr_do("R2 R3 R12 bad write", 12'(i * 4), s[0], 64'hFFFF_FFFF_FFFF_FFFF);
            end
        end
        readback_all("R12 unchanged");

        // R5 write patterns
        wr_do("R5", 12'h000, 0, 64'hDEAD_BEEF_1234_5678);
        wr_do("R5", 12'h008, 0, 64'h0000_0000_0000_00FF);
        wr_do("R5", 12'h014, 0, 64'h0000_0000_0000_0800);
        wr_do("R5", 12'h020, 1, 64'h0123_4567_89AB_CDEF);
        wr_do("R5", 12'h038, 1, 64'hFEDC_BA98_7654_3210);
        wr_do("R5", 12'h00C, 0, 64'd300);
        wr_do("R5", 12'h010, 0, 64'd500);
        readback_all("R5 written");

        // R6 R8 receive status sweep
        for (int c = 0; c < 256; c++) begin
            rx_pkt_count = 8'(c);
            rd_chk("R6 rx status", 12'h028, 4'(c), 1);
            rd_chk("R8 rx hold", 12'h030, 4'(c), 1);
        end
        // R7 R8 transmit status sweep across both thresholds
        for (int f = 0; f < 1024; f++) begin
            tx_free = 10'(f); tx_occupancy = 10'(1023 - f); tx_pkt_count = 8'(f * 3);
            rd_chk("R7 tx status", 12'h040, 4'(f), 1);
            if (f % 8 == 0) rd_chk("R8 tx hold", 12'h048, 4'(f), 1);
        end

        // R9 R10 parked receive read
        rx_idle = 0; rx_pkt_count = 8'd4;
        access(0, {4'h0, 12'h030}, 1, 64'h0, 4'd5, e, d, v, t);
        chk("R9 parked no rsp", {63'h0, v}, 64'h0);
        rd_chk("R9 other access while parked", 12'h000, 4'h6, 0);
        access(0, {4'h0, 12'h030}, 1, 64'h0, 4'd7, e, d, v, t);
        chk("R10 second hold err", {63'h0, e}, 64'h1);
        chk("R10 second hold tag", {60'h0, t}, 64'd7);
        rx_pkt_count = 8'd9; rx_idle = 1;
        #0;
        chk("R9 ready low at release", {63'h0, req_ready}, 64'h0);
        @(negedge clk);
        chk("R9 release valid", {63'h0, rsp_valid}, 64'h1);
        chk("R9 release tag", {60'h0, rsp_tag}, 64'd5);
        chk("R9 release live data", rsp_rdata, 64'd9);
        chk("R9 ready after release", {63'h0, req_ready}, 64'h1);

        // R9 both parked, both released together: receive first
        rx_idle = 0; tx_idle = 0;
        access(0, {4'h0, 12'h048}, 1, 64'h0, 4'd11, e, d, v, t);
        chk("R9 tx parked", {63'h0, v}, 64'h0);
        access(0, {4'h0, 12'h030}, 1, 64'h0, 4'd12, e, d, v, t);
        chk("R9 rx parked", {63'h0, v}, 64'h0);
        tx_free = 10'd1; tx_occupancy = 10'd1000; tx_pkt_count = 8'd2; rx_pkt_count = 8'd33;
        rx_idle = 1; tx_idle = 1;
        @(negedge clk);
        chk("R9 first release tag", {60'h0, rsp_tag}, 64'd12);
        chk("R9 first release data", rsp_rdata, rx_exp());
        chk("R9 ready low for tx", {63'h0, req_ready}, 64'h0);
        @(negedge clk);
        chk("R9 second release tag", {60'h0, rsp_tag}, 64'd11);
        chk("R9 second release data", rsp_rdata, tx_exp());
        @(negedge clk);
        chk("R9 no further rsp", {63'h0, rsp_valid}, 64'h0);

        // R11 command register
        access(1, {4'h0, 12'h004}, 0, 64'hFFFF_FFFE, 4'd1, e, d, v, t);
        chk("R11 no-op fifo_clear", {63'h0, fifo_clear}, 64'h0);
        readback_all("R11 no-op keeps state");
        access(1, {4'h0, 12'h004}, 0, 64'h1, 4'd2, e, d, v, t);
        chk("R11 clear pulse", {63'h0, fifo_clear}, 64'h1);
        model_defaults();
        @(negedge clk);
        chk("R11 clear one cycle", {63'h0, fifo_clear}, 64'h0);
        readback_all("R11 defaults restored");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule